// File: doc/BRIEF.md
# Vector Mask Compare and Masked Subtract Engine

This block carries out if-conversion for integer vector loops. It holds a file of vector registers and one mask register with one bit per element position. A compare command tests every element of a source vector against a scalar. It writes a 1 into the mask wherever the two differ and a 0 wherever they match. A later subtract command can then run under that mask. It writes the difference only into the elements whose mask bit is 1, and every other element of the destination keeps its old contents. A third command runs the same subtract with the mask ignored.

The engine steps through the elements one per clock, from element 0 up to the requested vector length. The run time therefore depends only on the length and not on how many elements the mask enables. A one-cycle done pulse marks the end of each command. A simple element write port and a combinational element read port let neighbouring load and store logic fill and drain the registers while the engine is idle. The mask is always visible on a 64-bit output.

Top module: `vmask_exec`

## Requirements
- R1: After reset, busy and done are 0 and every mask bit is 1, so a masked subtract issued before any compare writes every element below the vector length.
- R2: Command code 1 (compare-not-equal) sets mask bit i to 1 when element i of register va differs from the scalar, and to 0 when it equals the scalar, for every i below the vector length.
- R3: The compare clears every mask bit at or above the vector length; a compare with length 0 clears the whole mask.
- R4: Command code 2 (masked subtract) writes vd(i) = va(i) - vb(i), modulo 2^DW, for every i below the vector length whose mask bit is 1; vd may be the same register as va.
- R5: A masked subtract leaves unchanged every element of vd whose mask bit is 0, and every element at or above the vector length.
- R6: Command code 3 (unmasked subtract) writes va(i) - vb(i) into every element of vd below the vector length whatever the mask holds; neither subtract changes the mask.
- R7: When start is sampled at a rising edge with a non-zero command and length L, done is 1 for exactly one cycle, namely the cycle after the (L+1)-th rising edge counted from and including the start edge, whatever the mask holds; busy is 1 while elements are still being processed.
- R8: A vector length above 64 is treated as 64.
- R9: While busy is 1, a start request and the element write port are both ignored.
- R10: A start with command code 0 is ignored: no done pulse, no register or mask change.
- R11: When idle, ld_en writes ld_data into element ld_idx of register ld_reg at the next rising edge; rd_data always shows element rd_idx of register rd_reg.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to begin a command |
| cmd | input | 2 | 0 none, 1 compare-not-equal, 2 masked subtract, 3 unmasked subtract |
| vd | input | 3 | Destination register index |
| va | input | 3 | First source register index (compare source) |
| vb | input | 3 | Second source register index (subtrahend) |
| scalar | input | 16 | Scalar operand for the compare |
| vl | input | 7 | Vector length, clamped to 64 |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| mask | output | 64 | Current mask register |
| ld_en | input | 1 | Element write strobe (idle only) |
| ld_reg | input | 3 | Element write register index |
| ld_idx | input | 6 | Element write position |
| ld_data | input | 16 | Element write data |
| rd_reg | input | 3 | Element read register index |
| rd_idx | input | 6 | Element read position |
| rd_data | output | 16 | Element read data |

## Verification
The bench aims at the length boundary. A compare with a short length after a full mask must leave the upper bits at 0, or stale 1s would later enable writes that should not happen. A length of 0 must still clear the mask and finish in one cycle, and a length above 64 must stop at 64 rather than wrap the element index. An in-place masked subtract (vd equal to va) and a subtract issued straight after reset show whether disabled elements really keep their values and whether the reset mask behaves as all-enabled. Latency is timed against a sparse mask, which exposes a design that skips disabled elements. A start and an element write issued mid-run expose a design that lets either one corrupt the running command.

// File: rtl/vmask_pkg.sv
// Package: shared command encoding for the vector mask engine.
// Assumes commands arrive as a 2-bit code on the top-level port.
package vmask_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_CMPNE = 2'd1,
        OP_SUBM  = 2'd2,
        OP_SUBU  = 2'd3
    } op_e;

endpackage

// File: rtl/vmask_regfile.sv
// Vector register file: NREGS registers of VLMAX elements, DW bits each.
// One write port and three combinational read ports (two operands, one
// external). The data array has no reset; contents are defined by writes.
module vmask_regfile #(
    parameter int DW    = 16,
    parameter int NREGS = 8,
    parameter int VLMAX = 64,
    localparam int RW   = $clog2(NREGS),
    localparam int IW   = $clog2(VLMAX)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [RW-1:0] wreg,
    input  logic [IW-1:0] widx,
    input  logic [DW-1:0] wdata,
    input  logic [RW-1:0] ra_reg,
    input  logic [IW-1:0] ra_idx,
    output logic [DW-1:0] ra_data,
    input  logic [RW-1:0] rb_reg,
    input  logic [IW-1:0] rb_idx,
    output logic [DW-1:0] rb_data,
    input  logic [RW-1:0] rc_reg,
    input  logic [IW-1:0] rc_idx,
    output logic [DW-1:0] rc_data
);

    logic [DW-1:0] mem [NREGS][VLMAX];

    // Store one element per cycle through the single write port.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[wreg][widx] <= wdata;
        end
    end

    // Present the three addressed elements combinationally.
    always_comb begin
        ra_data = mem[ra_reg][ra_idx];
        rb_data = mem[rb_reg][rb_idx];
        rc_data = mem[rc_reg][rc_idx];
    end

endmodule

// File: rtl/vmask_seq.sv
// Command sequencer: accepts a command when idle, latches its operands,
// walks the element index from 0 to length-1 one step per clock, and
// raises done for one cycle after the last element. A length above VLMAX
// is clamped; a zero length completes at once without touching elements.
module vmask_seq
    import vmask_pkg::*;
#(
    parameter int DW    = 16,
    parameter int NREGS = 8,
    parameter int VLMAX = 64,
    localparam int RW   = $clog2(NREGS),
    localparam int IW   = $clog2(VLMAX),
    localparam int VLW  = $clog2(VLMAX + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  op_e            op_in,
    input  logic [RW-1:0]  vd_in,
    input  logic [RW-1:0]  va_in,
    input  logic [RW-1:0]  vb_in,
    input  logic [DW-1:0]  scalar_in,
    input  logic [VLW-1:0] vl_in,
    output logic           accept,
    output logic           busy,
    output logic           done,
    output logic [IW-1:0]  idx,
    output op_e            op_q,
    output logic [RW-1:0]  vd_q,
    output logic [RW-1:0]  va_q,
    output logic [RW-1:0]  vb_q,
    output logic [DW-1:0]  scalar_q
);

    logic [VLW-1:0] vl_q;
    logic [VLW-1:0] vl_eff;
    logic           last;

    // Clamp the requested length and detect the final element.
    always_comb begin
        vl_eff = (vl_in > VLW'(VLMAX)) ? VLW'(VLMAX) : vl_in;
        accept = start && !busy && (op_in != OP_NONE);
        last   = (VLW'(idx) + VLW'(1)) == vl_q;
    end

    // Capture commands, step the index and produce the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            idx      <= '0;
            op_q     <= OP_NONE;
            vd_q     <= '0;
            va_q     <= '0;
            vb_q     <= '0;
            scalar_q <= '0;
            vl_q     <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                op_q     <= op_in;
                vd_q     <= vd_in;
                va_q     <= va_in;
                vb_q     <= vb_in;
                scalar_q <= scalar_in;
                vl_q     <= vl_eff;
                idx      <= '0;
                if (vl_eff == '0) begin
                    done <= 1'b1;
                end else begin
                    busy <= 1'b1;
                end
            end else if (busy) begin
                if (last) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    idx <= idx + IW'(1);
                end
            end
        end
    end

    // R7: done never lasts longer than one cycle.
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: the running index stays below the latched (clamped) length.
    assert_idx_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (VLW'(idx) < vl_q));

    // R9: operands of a running command do not move when start is repeated.
    assert_hold_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last) |=> ($stable(op_q) && $stable(vd_q) && $stable(va_q)));

endmodule

// File: rtl/vmask_lane.sv
// Element lane: for the current element decides whether the destination
// is written (masked or unmasked subtract) and whether the mask bit is
// updated (compare-not-equal). Purely combinational.
module vmask_lane
    import vmask_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          active,
    input  op_e           op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [DW-1:0] scalar,
    input  logic          mbit,
    output logic          wen,
    output logic [DW-1:0] wdata,
    output logic          mset,
    output logic          mval
);

    // Form the write enable, difference and compare result.
    always_comb begin
        wen   = active && ((op == OP_SUBU) || ((op == OP_SUBM) && mbit));
        wdata = a - b;
        mset  = active && (op == OP_CMPNE);
        mval  = (a != scalar);
    end

endmodule

// File: rtl/vmask_maskreg.sv
// Mask register: one bit per element, all ones after reset. A clear
// request zeroes every bit (start of a compare); a set request writes one
// bit at the given position. The two never coincide.
module vmask_maskreg #(
    parameter int VLMAX = 64,
    localparam int IW   = $clog2(VLMAX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_all,
    input  logic             set_en,
    input  logic [IW-1:0]    set_idx,
    input  logic             set_val,
    output logic [VLMAX-1:0] mask
);

    // Hold, clear or update a single mask bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '1;
        end else if (clr_all) begin
            mask <= '0;
        end else if (set_en) begin
            mask[set_idx] <= set_val;
        end
    end

    // R7: without a clear, at most one mask bit changes per clock.
    assert_one_bit_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_all |=> ($countones(mask ^ $past(mask)) <= 1));

    // R3: a clear leaves the mask empty on the next cycle.
    assert_clear_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (mask == '0));

endmodule

// File: rtl/vmask_exec.sv
// Top: vector mask compare and masked subtract engine. Ties the sequencer,
// element lane, register file and mask register together. The external
// element write port is honoured only while no command runs.
module vmask_exec
    import vmask_pkg::*;
#(
    parameter int DW    = 16,
    parameter int NREGS = 8,
    parameter int VLMAX = 64,
    localparam int RW   = $clog2(NREGS),
    localparam int IW   = $clog2(VLMAX),
    localparam int VLW  = $clog2(VLMAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       cmd,
    input  logic [RW-1:0]    vd,
    input  logic [RW-1:0]    va,
    input  logic [RW-1:0]    vb,
    input  logic [DW-1:0]    scalar,
    input  logic [VLW-1:0]   vl,
    output logic             busy,
    output logic             done,
    output logic [VLMAX-1:0] mask,
    input  logic             ld_en,
    input  logic [RW-1:0]    ld_reg,
    input  logic [IW-1:0]    ld_idx,
    input  logic [DW-1:0]    ld_data,
    input  logic [RW-1:0]    rd_reg,
    input  logic [IW-1:0]    rd_idx,
    output logic [DW-1:0]    rd_data
);

    op_e           op_in;
    op_e           op_q;
    logic          accept;
    logic [IW-1:0] idx;
    logic [RW-1:0] vd_q, va_q, vb_q;
    logic [DW-1:0] scalar_q;
    logic [DW-1:0] a_data, b_data;
    logic          eng_wen, mset, mval;
    logic [DW-1:0] eng_wdata;
    logic          rf_we;
    logic [RW-1:0] rf_wreg;
    logic [IW-1:0] rf_widx;
    logic [DW-1:0] rf_wdata;

    // Decode the command code.
    always_comb op_in = op_e'(cmd);

    vmask_seq #(.DW(DW), .NREGS(NREGS), .VLMAX(VLMAX)) seq_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op_in(op_in),
        .vd_in(vd), .va_in(va), .vb_in(vb), .scalar_in(scalar), .vl_in(vl),
        .accept(accept), .busy(busy), .done(done), .idx(idx), .op_q(op_q),
        .vd_q(vd_q), .va_q(va_q), .vb_q(vb_q), .scalar_q(scalar_q)
    );

    vmask_lane #(.DW(DW)) lane_i (
        .active(busy), .op(op_q), .a(a_data), .b(b_data), .scalar(scalar_q),
        .mbit(mask[idx]), .wen(eng_wen), .wdata(eng_wdata),
        .mset(mset), .mval(mval)
    );

    // Select the register file writer: engine while busy, else load port.
    always_comb begin
        if (busy) begin
            rf_we    = eng_wen;
            rf_wreg  = vd_q;
            rf_widx  = idx;
            rf_wdata = eng_wdata;
        end else begin
            rf_we    = ld_en;
            rf_wreg  = ld_reg;
            rf_widx  = ld_idx;
            rf_wdata = ld_data;
        end
    end

    vmask_regfile #(.DW(DW), .NREGS(NREGS), .VLMAX(VLMAX)) rf_i (
        .clk(clk), .we(rf_we), .wreg(rf_wreg), .widx(rf_widx), .wdata(rf_wdata),
        .ra_reg(va_q), .ra_idx(idx), .ra_data(a_data),
        .rb_reg(vb_q), .rb_idx(idx), .rb_data(b_data),
        .rc_reg(rd_reg), .rc_idx(rd_idx), .rc_data(rd_data)
    );

    vmask_maskreg #(.VLMAX(VLMAX)) mask_i (
        .clk(clk), .rst_n(rst_n),
        .clr_all(accept && (op_in == OP_CMPNE)),
        .set_en(mset), .set_idx(idx), .set_val(mval), .mask(mask)
    );

    // R5: a masked subtract only writes where the mask bit is set.
    assert_masked_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_wen && (op_q == OP_SUBM)) |-> mask[idx]);

    // R9: the engine never writes the register file while idle.
    assert_no_idle_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !eng_wen);

    // R6: subtract commands leave the mask untouched.
    assert_sub_keeps_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (op_q != OP_CMPNE)) |=> $stable(mask));

endmodule

// File: tb/vmask_exec_tb.sv
`timescale 1ns/1ps
// Directed bench for vmask_exec with an independent reference model.
module vmask_exec_tb_top;

    localparam int DW = 16;
    localparam int NR = 8;
    localparam int VM = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    cmd = 2'd0;
    logic [2:0]    vd = '0, va = '0, vb = '0;
    logic [DW-1:0] scalar = '0;
    logic [6:0]    vl = '0;
    logic          busy, done;
    logic [VM-1:0] mask;
    logic          ld_en = 1'b0;
    logic [2:0]    ld_reg = '0;
    logic [5:0]    ld_idx = '0;
    logic [DW-1:0] ld_data = '0;
    logic [2:0]    rd_reg = '0;
    logic [5:0]    rd_idx = '0;
    logic [DW-1:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;

    logic [DW-1:0] mdl [NR][VM];
    logic [VM-1:0] mmask;

    always #2.5 clk = ~clk;

    vmask_exec dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .vd(vd), .va(va),
        .vb(vb), .scalar(scalar), .vl(vl), .busy(busy), .done(done),
        .mask(mask), .ld_en(ld_en), .ld_reg(ld_reg), .ld_idx(ld_idx),
        .ld_data(ld_data), .rd_reg(rd_reg), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    // Fill register r through the element port; values from seed, with
    // every third element equal to eqv.
    task automatic load_reg(input int r, input int seed, input logic [DW-1:0] eqv);
        for (int i = 0; i < VM; i++) begin
            @(negedge clk);
            ld_en   = 1'b1;
            ld_reg  = 3'(r);
            ld_idx  = 6'(i);
            ld_data = (i % 3 == 0) ? eqv : DW'(seed * 977 + i * i * 31 + i + 1);
            mdl[r][i] = ld_data;
        end
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic check_reg(input string req, input int r);
        for (int i = 0; i < VM; i++) begin
            rd_reg = 3'(r);
            rd_idx = 6'(i);
            #0.1;
            check(req, 64'(rd_data), 64'(mdl[r][i]));
        end
    endtask

    task automatic model_op(input int c, input int d, input int a, input int b,
                            input logic [DW-1:0] s, input int len);
        int l;
        l = (len > VM) ? VM : len;
        if (c == 1) begin
            mmask = '0;
            for (int i = 0; i < l; i++) mmask[i] = (mdl[a][i] != s);
        end else if (c == 2 || c == 3) begin
            for (int i = 0; i < l; i++)
                if (c == 3 || mmask[i]) mdl[d][i] = mdl[a][i] - mdl[b][i];
        end
    endtask

    // Issue a command, time it to done and update the model.
    task automatic run_op(input string req, input int c, input int d, input int a,
                          input int b, input logic [DW-1:0] s, input int len);
        int cnt;
        int l;
        l = (len > VM) ? VM : len;
        @(negedge clk);
        start = 1'b1; cmd = 2'(c); vd = 3'(d); va = 3'(a); vb = 3'(b);
        scalar = s; vl = 7'(len);
        @(negedge clk);
        start = 1'b0;
        cnt = 1;
        while (!done && cnt < 300) begin
            @(negedge clk);
            cnt++;
        end
        check({req, " R7 latency"}, 64'(cnt), 64'(l + 1));
        @(negedge clk);
        check("R7 done single cycle", 64'(done), 64'd0);
        model_op(c, d, a, b, s, len);
    endtask

    task automatic t_reset();
        check("R1 busy after reset", 64'(busy), 64'd0);
        check("R1 done after reset", 64'(done), 64'd0);
        check("R1 mask after reset", mask, {VM{1'b1}});
        load_reg(1, 3, 16'h0000);
        load_reg(2, 5, 16'h0007);
        check_reg("R11 load readback", 1);
        // Masked subtract with the reset mask enables every element.
        run_op("R1 masked sub on reset mask", 2, 3, 1, 2, '0, 64);
        check_reg("R1 all elements written", 3);
    endtask

    task automatic t_compare();
        run_op("R2 compare full", 1, 0, 1, 0, 16'h0000, 64);
        check("R2 mask full length", mask, mmask);
        run_op("R3 compare short", 1, 0, 2, 0, 16'h0007, 10);
        check("R3 bits above length cleared", mask, mmask);
        check("R3 upper bits zero", 64'(mask >> 10), 64'd0);
    endtask

    task automatic t_masked_sub();
        run_op("R2 compare for sub", 1, 0, 1, 0, 16'h0000, 64);
        load_reg(4, 9, 16'h1234);
        run_op("R4 masked sub", 2, 4, 1, 2, '0, 40);
        check_reg("R5 R4 masked destination", 4);
        check("R6 mask kept by masked sub", mask, mmask);
        // In place: X = X - Y where X != 0.
        run_op("R4 in place", 2, 1, 1, 2, '0, 64);
        check_reg("R4 R5 in place result", 1);
    endtask

    task automatic t_unmasked();
        run_op("R6 compare sparse", 1, 0, 2, 0, 16'h0007, 5);
        load_reg(5, 11, 16'hBEEF);
        run_op("R6 unmasked sub", 3, 5, 2, 1, '0, 50);
        check_reg("R6 unmasked destination", 5);
        check("R6 mask kept", mask, mmask);
    endtask

    task automatic t_lengths();
        run_op("R3 zero length", 1, 0, 1, 0, 16'h0000, 0);
        check("R3 zero length clears mask", mask, 64'd0);
        load_reg(6, 13, 16'h0001);
        run_op("R8 over length", 3, 6, 2, 1, '0, 100);
        check_reg("R8 clamped to 64", 6);
        run_op("R7 sparse mask timing", 2, 6, 1, 2, '0, 64);
        check_reg("R5 nothing written with empty mask", 6);
    endtask

    task automatic t_busy();
        int cnt;
        @(negedge clk);
        start = 1'b1; cmd = 2'd3; vd = 3'd7; va = 3'd1; vb = 3'd2; vl = 7'd20;
        @(negedge clk);
        start = 1'b1; cmd = 2'd1; va = 3'd2; scalar = 16'h0007; vl = 7'd64;
        ld_en = 1'b1; ld_reg = 3'd4; ld_idx = 6'd63; ld_data = 16'hDEAD;
        @(negedge clk);
        start = 1'b0; ld_en = 1'b0;
        cnt = 2;
        while (!done && cnt < 300) begin
            @(negedge clk);
            cnt++;
        end
        check("R9 latency of first command", 64'(cnt), 64'd21);
        model_op(3, 7, 1, 2, '0, 20);
        check("R9 mask untouched by ignored start", mask, mmask);
        check_reg("R9 ignored element write", 4);
        repeat (3) @(negedge clk);
        check("R9 no second done", 64'(done), 64'd0);
    endtask

    task automatic t_nop();
        int seen;
        seen = 0;
        @(negedge clk);
        start = 1'b1; cmd = 2'd0; vd = 3'd4; va = 3'd1; vb = 3'd2; vl = 7'd8;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 12; k++) begin
            if (done || busy) seen = 1;
            @(negedge clk);
        end
        check("R10 no activity on command 0", 64'(seen), 64'd0);
        check("R10 mask unchanged", mask, mmask);
        check_reg("R10 register unchanged", 4);
    endtask

    initial begin
        mmask = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_compare();
        t_masked_sub();
        t_unmasked();
        t_lengths();
        t_busy();
        t_nop();
        finish_run();
    end

endmodule